// File: doc/BRIEF.md
# Background Flash Streaming Engine

This block moves a contiguous run of 32-bit words out of flash into a two-word holding FIFO, which a DMA channel then drains. Software first loads a word-aligned start address, then loads a nonzero word count to start the transfer. From then on the engine raises a read request to the flash port. A request is accepted only in a cycle where the port reports that it has no other work (the idle grant). Each accepted request moves the address one word forward and takes one off the remaining count. The returned word lands in the FIFO.

The engine keeps at most one read in flight. It requests a new word only when the FIFO has room for that word and for anything already on its way, so the FIFO cannot overflow. Writing a count of zero cancels the stream at once. Each request carries a one-bit epoch tag, and a cancel flips the epoch, so a response that belongs to the cancelled stream is recognised and dropped. The FIFO's full and empty flags are driven on output pins and can also be read through the status register.

Top module: `flash_stream_engine`

## Requirements
- R1: After reset the address and the count both read 0, `flash_req` is 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: The register bus selects with `reg_sel`: 0 is the address, 1 is the count, 2 is the status and 3 is the FIFO data. An address write stores `reg_wdata` with bits 1:0 forced to 0, and a read returns the stored word address.
- R3: `flash_req` is 1 exactly when the count is nonzero, no read is in flight, and the FIFO holds fewer than 2 words. While it is 1, `flash_addr` shows the current address.
- R4: A request is taken only in a cycle where both `flash_req` and `flash_idle` are 1. With `flash_idle` at 0, the address and count stay unchanged and the request stays raised.
- R5: Each taken request adds 4 to the address and, unless the same cycle writes the count, subtracts 1 from the count. An address write in the same cycle wins.
- R6: Once the count reaches 0, no further request is raised, and the count reads 0.
- R7: At most one read is in flight. After a taken request, `flash_req` stays 0 until the matching response has arrived or the stream has been cancelled.
- R8: A response (`flash_resp_valid`) is written into the FIFO only if a read is in flight and `flash_resp_tag` equals the current epoch. A response that arrives with no read in flight is ignored.
- R9: The FIFO never holds more than 2 words, counting the words it holds plus any read in flight. With a full FIFO, `flash_req` is 0.
- R10: `fifo_full` is 1 when 2 words are held and `fifo_empty` is 1 when none are. Status bit 2 is the full flag, bit 1 is the empty flag, and every other status bit reads 0.
- R11: A read of the data register returns the oldest word and removes it from the FIFO. A read of an empty FIFO returns 0 and changes nothing.
- R12: Writing a count of 0 clears the count, ends the in-flight read and flips the epoch that `flash_req_tag` shows. A later response carrying the old epoch never enters the FIFO, even when a new stream has started in the meantime.
- R13: A FIFO pop and an accepted response in the same cycle leave the FIFO's word count unchanged and keep the words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (a read of the data register pops) |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 status, 3 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| flash_idle | input | 1 | Flash port has a free cycle for the stream |
| flash_req | output | 1 | Stream read request |
| flash_addr | output | 32 | Word-aligned request address |
| flash_req_tag | output | 1 | Epoch tag sent with the request |
| flash_resp_valid | input | 1 | Flash read data valid |
| flash_resp_tag | input | 1 | Epoch tag returned with the data |
| flash_resp_data | input | 32 | Flash read data |
| fifo_full | output | 1 | FIFO holds 2 words |
| fifo_empty | output | 1 | FIFO holds no words |

## Verification
Two pairs of events can land on the same clock edge. The DMA's pop of the data register can meet the arrival of a flash response, and a cancelling count write can meet a response or a request from the stream it ends. The bench finds the pop case by waiting until the responder is about to deliver while the FIFO holds exactly one word, then popping in that cycle. Both flags must then show one word held, and the later drain must come out in address order. For the cancel case, a long flash latency keeps an old-epoch response in flight across the abort and across the start of a new stream. Only the new stream's words may appear, and the reference model judges every output on every cycle.

// File: rtl/fse_pkg.sv
`timescale 1ns/1ps
package fse_pkg;

    // Register select codes on the register bus
    typedef enum logic [1:0] {
        SEL_ADDR   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_DATA   = 2'd3
    } reg_sel_e;

    // Status word field positions
    localparam int unsigned STAT_EMPTY_BIT = 1;
    localparam int unsigned STAT_FULL_BIT  = 2;
    localparam int unsigned STAT_W         = 3;

    // Decoded register-bus command for one cycle
    typedef struct packed {
        logic load_addr;
        logic load_count;
        logic pop;
    } reg_cmd_t;

    function automatic reg_cmd_t decode_cmd(input logic wr_en,
                                            input logic rd_en,
                                            input logic [1:0] sel);
        reg_cmd_t c;
        c.load_addr  = wr_en && (reg_sel_e'(sel) == SEL_ADDR);
        c.load_count = wr_en && (reg_sel_e'(sel) == SEL_COUNT);
        c.pop        = rd_en && (reg_sel_e'(sel) == SEL_DATA);
        return c;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input logic full,
                                                      input logic empty);
        logic [STAT_W-1:0] s;
        s = '0;
        s[STAT_FULL_BIT]  = full;
        s[STAT_EMPTY_BIT] = empty;
        return s;
    endfunction

endpackage

// File: rtl/fse_addr_gen.sv
`timescale 1ns/1ps
module fse_addr_gen #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    // Only the word index is stored; byte offset is always zero.
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= load_val[ADDR_W-1:2];
        end else if (step) begin
            word_q <= word_q + 1'b1;
        end
    end

    assign addr = {word_q, 2'b00};
endmodule

// File: rtl/fse_seq.sv
`timescale 1ns/1ps
module fse_seq #(
    parameter int unsigned CNT_W = 22,
    parameter int unsigned DEPTH = 2,
    parameter int unsigned LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             flash_idle,
    input  logic             resp_valid,
    input  logic             resp_tag,
    output logic             req,
    output logic             issue,
    output logic             accept,
    output logic             abort,
    output logic             outstanding,
    output logic             epoch,
    output logic [CNT_W-1:0] cnt
);
    localparam int unsigned SUM_W = LVL_W + 1;

    logic [SUM_W-1:0] committed;
    logic             room;

    // Words held plus words already promised must leave space for one more.
    assign committed = SUM_W'(fifo_level) + SUM_W'(outstanding);
    assign room      = committed < SUM_W'(DEPTH);

    assign abort  = cnt_load && (cnt_val == '0);
    assign req    = (cnt != '0) && !outstanding && room;
    assign issue  = req && flash_idle;
    assign accept = resp_valid && outstanding && (resp_tag == epoch) && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt_load) begin
            cnt <= cnt_val;
        end else if (issue) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            epoch       <= 1'b0;
        end else if (abort) begin
            outstanding <= 1'b0;
            epoch       <= ~epoch;
        end else if (issue) begin
            outstanding <= 1'b1;
        end else if (accept) begin
            outstanding <= 1'b0;
        end
    end
endmodule

// File: rtl/fse_fifo.sv
`timescale 1ns/1ps
module fse_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 2,
    parameter int unsigned LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = slots[rd_ptr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PTR_W'(g))) begin
                slots[g] <= push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push) wr_ptr <= bump(wr_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/flash_stream_engine.sv
`timescale 1ns/1ps
module flash_stream_engine
    import fse_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_W      = 22,
    parameter int unsigned FIFO_DEPTH = 2,
    parameter int unsigned REG_W      = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              flash_idle,
    output logic              flash_req,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_req_tag,
    input  logic              flash_resp_valid,
    input  logic              flash_resp_tag,
    input  logic [DATA_W-1:0] flash_resp_data,
    output logic              fifo_full,
    output logic              fifo_empty
);
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH + 1);

    reg_cmd_t          cmd;
    logic              issue, accept, abort, outstanding, epoch;
    logic [CNT_W-1:0]  cnt;
    logic [LVL_W-1:0]  fifo_level;
    logic [DATA_W-1:0] fifo_head;
    logic [ADDR_W-1:0] cur_addr;

    assign cmd = decode_cmd(reg_wr_en, reg_rd_en, reg_sel);

    fse_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load_addr),
        .load_val (reg_wdata[ADDR_W-1:0]),
        .step     (issue),
        .addr     (cur_addr)
    );

    fse_seq #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cnt_load    (cmd.load_count),
        .cnt_val     (reg_wdata[CNT_W-1:0]),
        .fifo_level  (fifo_level),
        .flash_idle  (flash_idle),
        .resp_valid  (flash_resp_valid),
        .resp_tag    (flash_resp_tag),
        .req         (flash_req),
        .issue       (issue),
        .accept      (accept),
        .abort       (abort),
        .outstanding (outstanding),
        .epoch       (epoch),
        .cnt         (cnt)
    );

    fse_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (accept),
        .push_data (flash_resp_data),
        .pop       (cmd.pop),
        .head      (fifo_head),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    assign flash_addr    = cur_addr;
    assign flash_req_tag = epoch;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_sel))
            SEL_ADDR:   reg_rdata = REG_W'(cur_addr);
            SEL_COUNT:  reg_rdata = REG_W'(cnt);
            SEL_STATUS: reg_rdata = REG_W'(pack_status(fifo_full, fifo_empty));
            SEL_DATA:   reg_rdata = fifo_empty ? '0 : REG_W'(fifo_head);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fse_checker.sv
`timescale 1ns/1ps
module fse_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 22,
    parameter int unsigned LVL_W  = 2,
    parameter int unsigned DEPTH  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              flash_req,
    input logic              flash_idle,
    input logic [ADDR_W-1:0] flash_addr,
    input logic              issue,
    input logic              abort,
    input logic              load_addr,
    input logic              load_count,
    input logic [CNT_W-1:0]  cnt,
    input logic [LVL_W-1:0]  level,
    input logic              push,
    input logic              outstanding,
    input logic              fifo_full,
    input logic              fifo_empty
);
    // R4: without an idle grant the request waits and nothing moves
    a_r4_hold_without_idle: assert property (@(posedge clk) disable iff (rst)
        (flash_req && !flash_idle && !load_addr && !load_count)
            |=> ($stable(flash_addr) && $stable(cnt)));

    // R5: a taken request advances the address by one word
    a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
        (issue && !load_addr) |=> (flash_addr == $past(flash_addr) + ADDR_W'(4)));

    // R6: an exhausted count never requests
    a_r6_zero_count_quiet: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> !flash_req);

    // R7: no second request while one read is in flight
    a_r7_single_flight: assert property (@(posedge clk) disable iff (rst)
        issue |=> !flash_req);

    // R8: an accepted response always leaves data behind
    a_r8_push_lands: assert property (@(posedge clk) disable iff (rst)
        push |=> !fifo_empty);

    // R9: held plus promised words stay within capacity
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (int'(level) + int'(outstanding)) <= int'(DEPTH));

    // R10: the two flags are never both set
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    // R12: cancel leaves nothing in flight and nothing requested
    a_r12_abort_clears: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!flash_req && !outstanding));
endmodule

bind flash_stream_engine fse_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LVL_W  (LVL_W),
    .DEPTH  (FIFO_DEPTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flash_req   (flash_req),
    .flash_idle  (flash_idle),
    .flash_addr  (flash_addr),
    .issue       (issue),
    .abort       (abort),
    .load_addr   (cmd.load_addr),
    .load_count  (cmd.load_count),
    .cnt         (cnt),
    .level       (fifo_level),
    .push        (accept),
    .outstanding (outstanding),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty)
);

// File: tb/flash_stream_engine_tb_top.sv
`timescale 1ns/1ps
module flash_stream_engine_tb_top;

    localparam int S_ADDR = 0, S_CNT = 1, S_STAT = 2, S_DATA = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 0, reg_rd_en = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        flash_idle = 0;
    logic        flash_req, flash_req_tag;
    logic [31:0] flash_addr;
    logic        flash_resp_valid = 0, flash_resp_tag = 0;
    logic [31:0] flash_resp_data = 0;
    logic        fifo_full, fifo_empty;

    always #10 clk = ~clk;   // 50 MHz

    flash_stream_engine dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flash_idle(flash_idle), .flash_req(flash_req), .flash_addr(flash_addr),
        .flash_req_tag(flash_req_tag), .flash_resp_valid(flash_resp_valid),
        .flash_resp_tag(flash_resp_tag), .flash_resp_data(flash_resp_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    int tests = 0, fails = 0, cyc = 0;

    // reference model state
    logic [31:0] m_addr = 0;
    int unsigned m_cnt = 0;
    bit          m_out = 0, m_epoch = 0;
    logic [31:0] m_fifo[$];

    // flash responder and stimulus knobs
    typedef struct { int due; logic tag; logic [31:0] data; } resp_t;
    resp_t       pend[$];
    int          last_due = -1;
    int          lat = 2;
    int          idle_mode = 1;
    bit          auto_pop = 0;
    logic [31:0] last_rd;
    logic [31:0] popped[$];

    function automatic logic [31:0] flash_word(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[17:2]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic tick();
        bit          m_req, issue, abort, accept, do_pop, auto_rd, wr_a, wr_c;
        logic [31:0] exp_rd, n_addr, rdata_in;
        int unsigned n_cnt;
        bit          n_out, n_epoch;
        string       rtag;

        flash_idle = (idle_mode == 1) || (idle_mode == 2 && (cyc % 3) == 0);
        if (pend.size() > 0 && pend[0].due <= cyc) begin
            flash_resp_valid = 1'b1;
            flash_resp_tag   = pend[0].tag;
            flash_resp_data  = pend[0].data;
            void'(pend.pop_front());
        end else begin
            flash_resp_valid = 1'b0;
            flash_resp_tag   = 1'b0;
            flash_resp_data  = '0;
        end
        auto_rd = 0;
        if (auto_pop && !reg_wr_en && !reg_rd_en && m_fifo.size() > 0) begin
            reg_rd_en = 1'b1;
            reg_sel   = 2'(S_DATA);
            auto_rd   = 1;
        end
        #1;
        m_req = (m_cnt != 0) && !m_out && (m_fifo.size() < 2);
        chk("R3/R7/R9", "flash_req", {31'b0, flash_req}, {31'b0, m_req});
        if (m_req) chk("R5", "flash_addr", flash_addr, m_addr);
        chk("R12", "flash_req_tag", {31'b0, flash_req_tag}, {31'b0, m_epoch});
        chk("R10", "fifo_full",  {31'b0, fifo_full},  {31'b0, m_fifo.size() == 2});
        chk("R10", "fifo_empty", {31'b0, fifo_empty}, {31'b0, m_fifo.size() == 0});
        if (reg_rd_en) begin
            case (int'(reg_sel))
                S_ADDR:  begin exp_rd = m_addr; rtag = "R2"; end
                S_CNT:   begin exp_rd = m_cnt;  rtag = "R6"; end
                S_STAT:  begin exp_rd = {29'b0, m_fifo.size() == 2, m_fifo.size() == 0, 1'b0}; rtag = "R10"; end
                default: begin exp_rd = (m_fifo.size() > 0) ? m_fifo[0] : 32'h0; rtag = "R11"; end
            endcase
            chk(rtag, "reg_rdata", reg_rdata, exp_rd);
            last_rd = reg_rdata;
            if (auto_rd) popped.push_back(reg_rdata);
        end
        if (flash_req && flash_idle) begin
            int due;
            due = cyc + lat;
            if (due <= last_due) due = last_due + 1;
            last_due = due;
            pend.push_back('{due, flash_req_tag, flash_word(flash_addr)});
        end
        wr_a     = reg_wr_en && int'(reg_sel) == S_ADDR;
        wr_c     = reg_wr_en && int'(reg_sel) == S_CNT;
        issue    = m_req && flash_idle;
        abort    = wr_c && reg_wdata[21:0] == 22'd0;
        accept   = flash_resp_valid && m_out && (flash_resp_tag == m_epoch) && !abort;
        do_pop   = reg_rd_en && int'(reg_sel) == S_DATA && m_fifo.size() > 0;
        rdata_in = flash_resp_data;
        n_addr   = wr_a ? {reg_wdata[31:2], 2'b00} : (issue ? m_addr + 32'd4 : m_addr);
        n_cnt    = wr_c ? int'(reg_wdata[21:0]) : (issue ? m_cnt - 1 : m_cnt);
        n_out    = abort ? 0 : (issue ? 1 : (accept ? 0 : m_out));
        n_epoch  = abort ? !m_epoch : m_epoch;
        @(posedge clk);
        m_addr = n_addr; m_cnt = n_cnt; m_out = n_out; m_epoch = n_epoch;
        if (do_pop) void'(m_fifo.pop_front());
        if (accept) m_fifo.push_back(rdata_in);
        cyc++;
        @(negedge clk);
        if (auto_rd) reg_rd_en = 1'b0;
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_sel = 2'(sel); reg_wdata = d;
        tick();
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int sel);
        reg_rd_en = 1'b1; reg_sel = 2'(sel);
        tick();
        reg_rd_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) tick();
    endtask

    task automatic settle();
        while (m_cnt != 0 || m_out || pend.size() > 0 || m_fifo.size() > 0) tick();
    endtask

    task automatic check_popped(input string req, input logic [31:0] base, input int n);
        chk(req, "words popped", popped.size(), n);
        for (int i = 0; i < n && i < popped.size(); i++)
            chk(req, "popped word order", popped[i], flash_word(base + 32'(4 * i)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hang expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "flash_req after reset", {31'b0, flash_req}, 0);
        chk("R1", "fifo_empty after reset", {31'b0, fifo_empty}, 1);
        chk("R1", "fifo_full after reset", {31'b0, fifo_full}, 0);
        idle_mode = 0;
        rd(S_STAT); chk("R1", "status after reset", last_rd, 32'h2);
        rd(S_ADDR); chk("R1", "address after reset", last_rd, 0);
        rd(S_CNT);  chk("R1", "count after reset", last_rd, 0);

        // R2: low address bits are dropped
        wr(S_ADDR, 32'hFFFF_FFFF); rd(S_ADDR);
        chk("R2", "aligned address", last_rd, 32'hFFFF_FFFC);

        // R8: a response with nothing in flight is ignored
        pend.push_back('{cyc, 1'b0, 32'hDEAD_BEEF});
        run(2);
        chk("R8", "stray response ignored", {31'b0, fifo_empty}, 1);

        // R4: no idle grant, request waits
        wr(S_ADDR, 32'h0000_0400); wr(S_CNT, 2); run(5);
        chk("R4", "request held", {31'b0, flash_req}, 1);
        rd(S_ADDR); chk("R4", "address unchanged", last_rd, 32'h400);
        rd(S_CNT);  chk("R4", "count unchanged", last_rd, 2);
        idle_mode = 1; auto_pop = 1; popped.delete();
        settle();
        check_popped("R4", 32'h400, 2);

        // R3, R5, R8: sparse idle grant, short latency
        idle_mode = 2; lat = 1; popped.delete();
        wr(S_ADDR, 32'h0000_0104); wr(S_CNT, 5);
        settle();
        check_popped("R8", 32'h104, 5);
        rd(S_CNT); chk("R6", "count exhausted", last_rd, 0);
        chk("R6", "no request at zero count", {31'b0, flash_req}, 0);

        // R9: no pops, FIFO fills and requests stop
        auto_pop = 0; lat = 3; popped.delete();
        wr(S_ADDR, 32'h0000_0800); wr(S_CNT, 4); run(30);
        chk("R9", "fifo full", {31'b0, fifo_full}, 1);
        chk("R9", "request withheld", {31'b0, flash_req}, 0);
        rd(S_CNT); chk("R9", "only two issued", last_rd, 2);
        auto_pop = 1; settle();
        check_popped("R9", 32'h800, 4);

        // R12: cancel with a read in flight
        auto_pop = 0; idle_mode = 1; lat = 6;
        wr(S_ADDR, 32'h0000_1000); wr(S_CNT, 10); run(2);
        wr(S_CNT, 0); idle_mode = 0; run(10);
        chk("R12", "stale data dropped", {31'b0, fifo_empty}, 1);
        chk("R12", "no request after cancel", {31'b0, flash_req}, 0);
        rd(S_CNT); chk("R12", "count cleared", last_rd, 0);

        // R12: cancel then restart while the old read is still in flight
        idle_mode = 1; popped.delete();
        wr(S_ADDR, 32'h0000_2000); wr(S_CNT, 3); run(2);
        wr(S_CNT, 0); wr(S_CNT, 2);
        auto_pop = 1; settle();
        check_popped("R12", 32'h2004, 2);

        // R11: read of empty FIFO
        auto_pop = 0;
        rd(S_DATA); chk("R11", "empty read value", last_rd, 0);
        chk("R11", "empty read keeps empty", {31'b0, fifo_empty}, 1);

        // R13: pop coinciding with a response
        lat = 2; popped.delete();
        wr(S_ADDR, 32'h0000_3000); wr(S_CNT, 3);
        begin
            bit hit = 0;
            for (int i = 0; i < 60 && !hit; i++) begin
                if (pend.size() > 0 && pend[0].due <= cyc && m_fifo.size() == 1) begin
                    rd(S_DATA);
                    popped.push_back(last_rd);
                    hit = 1;
                    chk("R13", "level kept: not empty", {31'b0, fifo_empty}, 0);
                    chk("R13", "level kept: not full", {31'b0, fifo_full}, 0);
                end else begin
                    tick();
                end
            end
            chk("R13", "coincidence reached", {31'b0, hit}, 1);
        end
        auto_pop = 1; settle();
        check_popped("R13", 32'h3000, 3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule